// File: doc/BRIEF.md
# Rail Fault Response and Retry Controller

This block sits between per-rail voltage monitoring and the rail sequencer. Each monitored rail, input or output, delivers debounced overvoltage and undervoltage fault events. Each event type on each rail carries its own 2-bit response code. The block decides what the supply as a whole must do. It may carry on, shut down for good, or shut down and power up again a limited or unlimited number of times. It tells the sequencer through a shutdown request level and a one-cycle restart request.

A restart never begins while any output rail still reports power good. Once every output power-good flag has dropped, a global delay runs, and only then is the restart issued. The retry limit and the restart delay are shared by all rails. The response codes are held per rail. All of them, plus a clear command, are written through a small address/data write port. When a finite retry budget runs out, the controller holds the rails off until a clear command arrives.

Top module: `rail_fault_retry`

## Requirements
- R1: After reset, shut_req, restart_req and latched_off are 0, and every rail's responses hold the default code 01 (shutdown) for both fault types.
- R2: A write to address i (i below the rail count) sets rail i's overvoltage response from wdata[1:0] and its undervoltage response from wdata[3:2]. The codes are 00 ignore, 01 shutdown, 10 limited retry and 11 endless retry. An event of one type uses only its own field.
- R3: A fault event whose selected response is 00 leaves shut_req, restart_req and latched_off unchanged.
- R4: A fault event with response 01 raises shut_req and latched_off on the clock edge that samples it, and both stay high until a clear command.
- R5: A fault event with response 10 raises shut_req and starts a restart cycle while the retry count is below the limit. When the count has reached the limit, the event latches the controller off instead.
- R6: Writing address NUM_RAILS sets the global retry limit: 0 becomes 1, values above 6 become 6, and 1 to 6 are kept.
- R7: A fault event with response 11 always starts a restart cycle and never latches the controller off.
- R8: After a shutdown, the delay timer starts only at the first edge that samples every output power-good flag low. restart_req rises D+1 edges later, where D is the delay written at address NUM_RAILS+1.
- R9: Any write to address NUM_RAILS+2 is a clear command. It zeroes the retry count. If the controller is latched off, the clear drops latched_off and proceeds to the power-good wait and delay before a restart.
- R10: The retry count returns to zero on any edge in the running state that samples all output power-good flags high with no acted-on fault.
- R11: When several rails or fault types report in the same cycle, the most severe response is applied, ranked shutdown > limited retry > endless retry > ignore.
- R12: Fault events that arrive while the rails are shut down, waiting or in the delay do not change latched_off and do not start another cycle.
- R13: restart_req is a single-cycle pulse that coincides with shut_req falling.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register address |
| cfg_wdata | input | DLY_W | Register write data |
| ov_evt | input | N_VIN+N_VOUT | Debounced overvoltage fault event per rail |
| uv_evt | input | N_VIN+N_VOUT | Debounced undervoltage fault event per rail |
| pg_out | input | N_VOUT | Power-good flags of the output rails |
| shut_req | output | 1 | Request to the sequencer to power the rails down |
| restart_req | output | 1 | One-cycle request to power the rails back up |
| latched_off | output | 1 | Retry budget spent or shutdown response taken; clear needed |

## Verification
The hardest state to reach is retry exhaustion. The retry count advances only on faults that arrive while the rails are running and not yet fully powered. A single edge with every output rail powered wipes the count. The stimulus therefore keeps all power-good flags low across several complete shutdown, delay and restart cycles and injects a fault after each restart. It raises the flags for exactly one edge only when testing the count reset. The same approach, with two simultaneous events against a limit of one, shows that limited retry outranks endless retry.

// File: rtl/rfr_pkg.sv
package rfr_pkg;

  localparam logic [1:0] RSP_IGNORE    = 2'b00;
  localparam logic [1:0] RSP_SHUT      = 2'b01;
  localparam logic [1:0] RSP_RETRY_N   = 2'b10;
  localparam logic [1:0] RSP_RETRY_ALL = 2'b11;

  localparam int unsigned RETRY_MAX = 6;
  localparam int unsigned RETRY_W   = 3;

  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_WAIT_PG = 2'd1,
    ST_DELAY   = 2'd2,
    ST_LOCK    = 2'd3
  } ctrl_state_e;

  // severity rank: higher wins when several events coincide
  function automatic logic [1:0] resp_rank(input logic [1:0] code);
    case (code)
      RSP_SHUT:      return 2'd3;
      RSP_RETRY_N:   return 2'd2;
      RSP_RETRY_ALL: return 2'd1;
      default:       return 2'd0;
    endcase
  endfunction

  function automatic logic [1:0] rank_resp(input logic [1:0] rank);
    case (rank)
      2'd3:    return RSP_SHUT;
      2'd2:    return RSP_RETRY_N;
      2'd1:    return RSP_RETRY_ALL;
      default: return RSP_IGNORE;
    endcase
  endfunction

endpackage

// File: rtl/rfr_cfg_regs.sv
module rfr_cfg_regs
  import rfr_pkg::*;
#(
  parameter int          NUM_RAILS = 6,
  parameter int          DLY_W     = 16,
  parameter int          ADDR_W    = 4,
  parameter logic [3:0]  DEF_RESP  = 4'h5,
  parameter int          DEF_LIMIT = 3,
  parameter int          DEF_DELAY = 8
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            we,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [DLY_W-1:0]                wdata,
  output logic [NUM_RAILS-1:0][1:0]       ov_code,
  output logic [NUM_RAILS-1:0][1:0]       uv_code,
  output logic [RETRY_W-1:0]              limit,
  output logic [DLY_W-1:0]                delay,
  output logic                            clear
);

  localparam logic [ADDR_W-1:0] A_LIMIT = ADDR_W'(NUM_RAILS);
  localparam logic [ADDR_W-1:0] A_DELAY = ADDR_W'(NUM_RAILS + 1);
  localparam logic [ADDR_W-1:0] A_CLEAR = ADDR_W'(NUM_RAILS + 2);

  // per-rail response words: [1:0] overvoltage, [3:2] undervoltage
  for (genvar g = 0; g < NUM_RAILS; g++) begin : g_rail
    logic [3:0] word_q;
    always_ff @(posedge clk) begin
      if (rst)
        word_q <= DEF_RESP;
      else if (we && addr == ADDR_W'(g))
        word_q <= wdata[3:0];
    end
    assign ov_code[g] = word_q[1:0];
    assign uv_code[g] = word_q[3:2];
  end

  function automatic logic [RETRY_W-1:0] clamp_limit(input logic [DLY_W-1:0] v);
    if (v == '0)                   return RETRY_W'(1);
    else if (v > DLY_W'(RETRY_MAX)) return RETRY_W'(RETRY_MAX);
    else                           return v[RETRY_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      limit <= RETRY_W'(DEF_LIMIT);
      delay <= DLY_W'(DEF_DELAY);
      clear <= 1'b0;
    end else begin
      clear <= we && (addr == A_CLEAR);
      if (we && addr == A_LIMIT) limit <= clamp_limit(wdata);
      if (we && addr == A_DELAY) delay <= wdata;
    end
  end

  a_r6_limit_range: assert property (@(posedge clk) disable iff (rst)
    (limit >= RETRY_W'(1)) && (limit <= RETRY_W'(RETRY_MAX)));

  a_r9_clear_pulse: assert property (@(posedge clk) disable iff (rst)
    $past(we && addr == A_CLEAR) |-> clear);

endmodule

// File: rtl/rfr_fault_merge.sv
module rfr_fault_merge
  import rfr_pkg::*;
#(
  parameter int NUM_RAILS = 6
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_RAILS-1:0]      ov_evt,
  input  logic [NUM_RAILS-1:0]      uv_evt,
  input  logic [NUM_RAILS-1:0][1:0] ov_code,
  input  logic [NUM_RAILS-1:0][1:0] uv_code,
  output logic [1:0]                act_code
);

  logic [NUM_RAILS-1:0][1:0] rail_rank;
  logic [NUM_RAILS-1:0]      rail_shut;

  for (genvar g = 0; g < NUM_RAILS; g++) begin : g_rank
    logic [1:0] ov_r, uv_r;
    assign ov_r         = ov_evt[g] ? resp_rank(ov_code[g]) : 2'd0;
    assign uv_r         = uv_evt[g] ? resp_rank(uv_code[g]) : 2'd0;
    assign rail_rank[g] = (ov_r > uv_r) ? ov_r : uv_r;
    assign rail_shut[g] = (ov_evt[g] && ov_code[g] == RSP_SHUT) ||
                          (uv_evt[g] && uv_code[g] == RSP_SHUT);
  end

  logic [1:0] best;
  always_comb begin
    best = 2'd0;
    for (int i = 0; i < NUM_RAILS; i++)
      if (rail_rank[i] > best) best = rail_rank[i];
  end

  assign act_code = rank_resp(best);

  a_r11_shut_wins: assert property (@(posedge clk) disable iff (rst)
    (|rail_shut) |-> (act_code == RSP_SHUT));

  a_r3_quiet_no_action: assert property (@(posedge clk) disable iff (rst)
    (ov_evt == '0 && uv_evt == '0) |-> (act_code == RSP_IGNORE));

endmodule

// File: rtl/rfr_ctrl.sv
module rfr_ctrl
  import rfr_pkg::*;
#(
  parameter int N_VOUT = 4,
  parameter int DLY_W  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         act_code,
  input  logic [N_VOUT-1:0]  pg,
  input  logic [RETRY_W-1:0] limit,
  input  logic [DLY_W-1:0]   delay,
  input  logic               clear,
  output logic               shut_o,
  output logic               restart_o,
  output logic               lock_o
);

  ctrl_state_e        state;
  logic [RETRY_W-1:0] retry_cnt;
  logic [DLY_W-1:0]   tmr;
  logic               pg_all_low, pg_all_high;

  assign pg_all_low  = ~|pg;
  assign pg_all_high = &pg;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_RUN;
      retry_cnt <= '0;
      tmr       <= '0;
      shut_o    <= 1'b0;
      restart_o <= 1'b0;
      lock_o    <= 1'b0;
    end else begin
      restart_o <= 1'b0;
      if (clear) retry_cnt <= '0;
      case (state)
        ST_RUN: begin
          if (act_code == RSP_SHUT) begin
            state  <= ST_LOCK;
            shut_o <= 1'b1;
            lock_o <= 1'b1;
          end else if (act_code == RSP_RETRY_N) begin
            shut_o <= 1'b1;
            if (retry_cnt >= limit) begin
              state  <= ST_LOCK;
              lock_o <= 1'b1;
            end else begin
              state     <= ST_WAIT_PG;
              retry_cnt <= retry_cnt + 1'b1;
            end
          end else if (act_code == RSP_RETRY_ALL) begin
            state  <= ST_WAIT_PG;
            shut_o <= 1'b1;
          end else if (pg_all_high) begin
            retry_cnt <= '0;
          end
        end
        ST_WAIT_PG: begin
          if (pg_all_low) begin
            state <= ST_DELAY;
            tmr   <= '0;
          end
        end
        ST_DELAY: begin
          if (tmr >= delay) begin
            state     <= ST_RUN;
            shut_o    <= 1'b0;
            restart_o <= 1'b1;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        default: begin
          if (clear) begin
            state  <= ST_WAIT_PG;
            lock_o <= 1'b0;
          end
        end
      endcase
    end
  end

  a_r13_single_pulse: assert property (@(posedge clk) disable iff (rst)
    restart_o |=> !restart_o);

  a_r13_release_with_restart: assert property (@(posedge clk) disable iff (rst)
    restart_o |-> (!shut_o && $past(shut_o)));

  a_r4_lock_keeps_shut: assert property (@(posedge clk) disable iff (rst)
    lock_o |-> shut_o);

  a_r5_count_cap: assert property (@(posedge clk) disable iff (rst)
    retry_cnt <= RETRY_W'(RETRY_MAX));

  a_r8_pg_gate: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DELAY && $past(state) == ST_WAIT_PG) |-> $past(pg_all_low));

  a_r9_clear_unlocks: assert property (@(posedge clk) disable iff (rst)
    (lock_o && clear) |=> !lock_o);

  a_r12_masked_while_down: assert property (@(posedge clk) disable iff (rst)
    (state != ST_RUN && !clear) |=> $stable(lock_o));

endmodule

// File: rtl/rail_fault_retry.sv
module rail_fault_retry
  import rfr_pkg::*;
#(
  parameter int         N_VIN     = 2,
  parameter int         N_VOUT    = 4,
  parameter int         DLY_W     = 16,
  parameter int         ADDR_W    = $clog2(N_VIN + N_VOUT + 3),
  parameter logic [3:0] DEF_RESP  = 4'h5,
  parameter int         DEF_LIMIT = 3,
  parameter int         DEF_DELAY = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cfg_we,
  input  logic [ADDR_W-1:0]         cfg_addr,
  input  logic [DLY_W-1:0]          cfg_wdata,
  input  logic [N_VIN+N_VOUT-1:0]   ov_evt,
  input  logic [N_VIN+N_VOUT-1:0]   uv_evt,
  input  logic [N_VOUT-1:0]         pg_out,
  output logic                      shut_req,
  output logic                      restart_req,
  output logic                      latched_off
);

  localparam int NUM_RAILS = N_VIN + N_VOUT;

  logic [NUM_RAILS-1:0][1:0] ov_code, uv_code;
  logic [RETRY_W-1:0]        limit;
  logic [DLY_W-1:0]          delay;
  logic                      clear;
  logic [1:0]                act_code;

  rfr_cfg_regs #(
    .NUM_RAILS (NUM_RAILS),
    .DLY_W     (DLY_W),
    .ADDR_W    (ADDR_W),
    .DEF_RESP  (DEF_RESP),
    .DEF_LIMIT (DEF_LIMIT),
    .DEF_DELAY (DEF_DELAY)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .we      (cfg_we),
    .addr    (cfg_addr),
    .wdata   (cfg_wdata),
    .ov_code (ov_code),
    .uv_code (uv_code),
    .limit   (limit),
    .delay   (delay),
    .clear   (clear)
  );

  rfr_fault_merge #(
    .NUM_RAILS (NUM_RAILS)
  ) u_merge (
    .clk      (clk),
    .rst      (rst),
    .ov_evt   (ov_evt),
    .uv_evt   (uv_evt),
    .ov_code  (ov_code),
    .uv_code  (uv_code),
    .act_code (act_code)
  );

  rfr_ctrl #(
    .N_VOUT (N_VOUT),
    .DLY_W  (DLY_W)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .act_code  (act_code),
    .pg        (pg_out),
    .limit     (limit),
    .delay     (delay),
    .clear     (clear),
    .shut_o    (shut_req),
    .restart_o (restart_req),
    .lock_o    (latched_off)
  );

endmodule

// File: tb/test_rail_fault_retry.sv
`timescale 1ns/1ps
module test_rail_fault_retry;

  localparam int NR     = 6;
  localparam int NVOUT  = 4;
  localparam int A_LIM  = NR;
  localparam int A_DLY  = NR + 1;
  localparam int A_CLR  = NR + 2;
  localparam int DLY    = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [NR-1:0] ov_evt = '0, uv_evt = '0;
  logic [NVOUT-1:0] pg_out = '0;
  logic shut_req, restart_req, latched_off;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rail_fault_retry i_rail_fault_retry (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ov_evt(ov_evt), .uv_evt(uv_evt),
    .pg_out(pg_out), .shut_req(shut_req), .restart_req(restart_req),
    .latched_off(latched_off)
  );

  // vector: {rail[2:0], is_uv, word[3:0], exp_shut, exp_lock}
  localparam int NV = 10;
  localparam logic [9:0] VEC [0:NV-1] = '{
    {3'd0, 1'b0, 4'b0000, 1'b0, 1'b0},  // R3 ignore
    {3'd0, 1'b0, 4'b0001, 1'b1, 1'b1},  // R4 shutdown
    {3'd1, 1'b1, 4'b1000, 1'b1, 1'b0},  // R5 limited retry
    {3'd2, 1'b0, 4'b0011, 1'b1, 1'b0},  // R7 endless retry
    {3'd3, 1'b1, 4'b0000, 1'b0, 1'b0},  // R3 ignore on uv
    {3'd5, 1'b1, 4'b0100, 1'b1, 1'b1},  // R4 on last rail
    {3'd4, 1'b0, 4'b0010, 1'b1, 1'b0},  // R5
    {3'd5, 1'b0, 4'b0011, 1'b1, 1'b0},  // R7
    {3'd2, 1'b1, 4'b0001, 1'b0, 1'b0},  // R2 uv uses only [3:2]
    {3'd2, 1'b0, 4'b0100, 1'b0, 1'b0}   // R2 ov uses only [1:0]
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = 16'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse(input logic [NR-1:0] ov, input logic [NR-1:0] uv);
    @(negedge clk);
    ov_evt = ov; uv_evt = uv;
    @(negedge clk);
    ov_evt = '0; uv_evt = '0;
  endtask

  // counts negedges until restart_req is seen; 0 if none within limit
  task automatic wait_restart(input string req, output int n);
    n = 0;
    for (int k = 1; k <= 60; k++) begin
      @(negedge clk);
      if (restart_req) begin n = k; break; end
    end
    chk({req, " restart seen"}, int'(n != 0), 1);
    if (n != 0) begin
      chk("R13 shut low at restart", int'(shut_req), 0);
      @(negedge clk);
      chk("R13 restart one cycle", int'(restart_req), 0);
    end
  endtask

  task automatic unlock(input string req);
    int n;
    wr(A_CLR, 0);
    wait_restart(req, n);
    chk({req, " unlocked"}, int'(latched_off), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 shut after reset", int'(shut_req), 0);
    chk("R1 restart after reset", int'(restart_req), 0);
    chk("R1 lock after reset", int'(latched_off), 0);
    pulse(6'b000001, '0);
    chk("R1 default response shutdown", int'(latched_off), 1);
    unlock("R9");

    wr(A_LIM, 6);
    wr(A_DLY, DLY);

    for (int v = 0; v < NV; v++) begin
      logic [2:0] rail;
      logic uvf;
      logic [NR-1:0] m;
      rail = VEC[v][9:7];
      uvf  = VEC[v][6];
      m    = NR'(1) << rail;
      wr(A_CLR, 0);
      wr(int'(rail), int'(VEC[v][5:2]));
      pulse(uvf ? '0 : m, uvf ? m : '0);
      chk($sformatf("R2 vec%0d shut", v), int'(shut_req), int'(VEC[v][1]));
      chk($sformatf("R2 vec%0d lock", v), int'(latched_off), int'(VEC[v][0]));
      if (VEC[v][0]) begin
        repeat (3) @(negedge clk);
        chk("R4 lock holds", int'(latched_off), 1);
        unlock("R9");
      end else if (VEC[v][1]) begin
        wait_restart("R8", n);
        chk("R8 delay from pg low", n, DLY + 2);
      end else begin
        repeat (3) @(negedge clk);
        chk("R3 no restart", int'(restart_req), 0);
        chk("R3 no shut", int'(shut_req), 0);
      end
    end

    // R8 / R12: restart waits for every output power-good flag
    wr(1, 4'b0011);
    wr(0, 4'b0001);
    pg_out = 4'b0010;
    pulse(6'b000010, '0);
    chk("R8 shut on endless retry", int'(shut_req), 1);
    pulse(6'b000001, '0);
    chk("R12 masked shutdown fault", int'(latched_off), 0);
    repeat (10) @(negedge clk);
    chk("R8 held while pg high", int'(shut_req), 1);
    chk("R12 lock still clear", int'(latched_off), 0);
    pg_out = '0;
    wait_restart("R8", n);
    chk("R8 delay after pg drop", n, DLY + 2);

    // R5: limit 2 exhausts on third fault
    wr(A_CLR, 0);
    wr(A_LIM, 2);
    wr(2, 4'b0010);
    for (int k = 0; k < 2; k++) begin
      pulse(6'b000100, '0);
      chk("R5 retry within limit", int'(latched_off), 0);
      wait_restart("R5", n);
    end
    pulse(6'b000100, '0);
    chk("R5 limit exhausted", int'(latched_off), 1);
    unlock("R9");

    // R10: full power-up resets the count
    wr(A_LIM, 1);
    wr(A_CLR, 0);
    pulse(6'b000100, '0);
    chk("R10 first retry", int'(latched_off), 0);
    wait_restart("R10", n);
    @(negedge clk); pg_out = 4'hF;
    @(negedge clk); pg_out = '0;
    pulse(6'b000100, '0);
    chk("R10 count cleared", int'(latched_off), 0);
    wait_restart("R10", n);
    pulse(6'b000100, '0);
    chk("R10 count counts again", int'(latched_off), 1);
    unlock("R9");

    // R6: limit 0 clamps to 1
    wr(A_LIM, 0);
    wr(A_CLR, 0);
    pulse(6'b000100, '0);
    chk("R6 zero clamps to one", int'(latched_off), 0);
    wait_restart("R6", n);
    pulse(6'b000100, '0);
    chk("R6 one retry only", int'(latched_off), 1);
    unlock("R9");

    // R6: large limit clamps to 6
    wr(A_LIM, 200);
    wr(A_CLR, 0);
    for (int k = 0; k < 6; k++) begin
      pulse(6'b000100, '0);
      wait_restart("R6", n);
    end
    chk("R6 six retries allowed", int'(latched_off), 0);
    pulse(6'b000100, '0);
    chk("R6 seventh locks", int'(latched_off), 1);
    unlock("R9");

    // R7: endless retry never locks, even with limit 1
    wr(A_LIM, 1);
    wr(3, 4'b1100);
    for (int k = 0; k < 3; k++) begin
      pulse('0, 6'b001000);
      chk("R7 no lock", int'(latched_off), 0);
      wait_restart("R7", n);
    end

    // R11: shutdown beats limited retry in the same cycle
    wr(0, 4'b0001);
    wr(1, 4'b1000);
    wr(A_CLR, 0);
    pulse(6'b000001, 6'b000010);
    chk("R11 shutdown wins", int'(latched_off), 1);
    unlock("R9");

    // R11: limited retry beats endless retry
    wr(A_CLR, 0);
    pulse('0, 6'b000010);
    chk("R11 first limited retry", int'(latched_off), 0);
    wait_restart("R11", n);
    pulse('0, 6'b001010);
    chk("R11 limited retry wins", int'(latched_off), 1);
    unlock("R9");

    repeat (2) @(negedge clk);
    summary();
  end

endmodule